// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which device may interrupt a processor, and when. Each of up to eight request lines has a priority level and a handler address, both written through a small configuration port. The controller keeps a processor status word made of the current priority level and a privileged/user flag. A request interrupts only when its level is strictly above the running level. When it does, the controller saves the resume address and the status word on an internal hardware stack. It then raises the level to that of the source, switches to privileged state, and gives the processor a new program counter taken from the source's table entry.

A return-from-interrupt strobe pops the stack and restores both the saved counter and the saved status word, so handlers can nest to the stack's depth. Requests that lost, or that were not above the level, are held by their devices until a return lowers the level. A software trap strobe also saves the counter and status and enters privileged state. It jumps to a fixed trap address and leaves the level as it was. Stack misuse is reported through two sticky error flags. The processor is modelled only by its counter input and the load outputs.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset the level is 0, the state is user (priv 0), the stack depth is 0, both error flags are 0, and pc_load_o and irq_taken_o are 0.
- R2: A request is eligible only if its priority is strictly greater than the current level. Among eligible requests, the highest priority wins. On a tie, the lowest source index wins, and that index appears on irq_id_o.
- R3: When an interrupt is accepted, in the cycle after the request is sampled: the depth grows by one, the level equals the winner's priority, priv is 1, pc_load_o is 1, and pc_new_o is the winner's table address.
- R4: irq_taken_o is high for exactly one cycle per accepted interrupt. A request held high is not taken again while the level is at or above its priority.
- R5: A request that is not above the level stays pending. It is taken once a return brings the level below its priority.
- R6: A return with a non-empty stack pops one entry. The next cycle shows the saved level and priv, pc_load_o is 1, and pc_new_o is the saved counter.
- R7: A trap pushes the counter and status, sets priv to 1, leaves the level unchanged, and loads pc_new_o with TRAP_VEC (default 16'h0080).
- R8: Only one event is served per cycle, in this order: return first, then trap, then interrupt. An interrupt that loses stays pending.
- R9: The stack holds STACK_DEPTH entries (default 8). A trap or interrupt on a full stack changes no state and gives no load or taken pulse. It sets ovf_err_o, which stays set until reset.
- R10: A return on an empty stack changes no state and gives no load. It sets unf_err_o, which stays set until reset.
- R11: A configuration write (cfg_we_i) stores cfg_prio_i and cfg_vec_i for source cfg_idx_i. Arbitration uses the new values from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_SRC | Level-sensitive request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source index to configure |
| cfg_prio_i | input | LVL_W | Priority for that source |
| cfg_vec_i | input | PC_W | Handler address for that source |
| pc_i | input | PC_W | Resume address of the running code |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| trap_i | input | 1 | Software trap strobe |
| pc_load_o | output | 1 | New program counter is valid this cycle |
| pc_new_o | output | PC_W | Program counter to load |
| psr_level_o | output | LVL_W | Current priority level |
| psr_priv_o | output | 1 | Privileged state |
| irq_taken_o | output | 1 | One-cycle pulse on interrupt entry |
| irq_id_o | output | IDX_W | Source that was taken |
| depth_o | output | CNT_W | Stack entries in use |
| ovf_err_o | output | 1 | Sticky push-on-full error |
| unf_err_o | output | 1 | Sticky pop-on-empty error |

## Verification
Directed sequences cover the cases that tell the possible designs apart. Two sources with equal priority tell the tie rule from an arbitrary choice. A request at exactly the current level tells strict from non-strict comparison. A nested higher request followed by two returns tells a stack from a single save register. Strobes that coincide in one cycle tell the serving order. Nine pushes in a row check the overflow boundary, and a return right after reset checks underflow. Seeded random traffic of requests, returns, traps and reconfiguration then runs against a reference model in the bench, which finds ordering and restore errors that the directed cases miss.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RET  = 2'd1,
        EV_TRAP = 2'd2,
        EV_IRQ  = 2'd3
    } nic_event_e;
endpackage

// File: rtl/nic_cfg_table.sv
module nic_cfg_table #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int PC_W    = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [LVL_W-1:0]         prio_i,
    input  logic [PC_W-1:0]          vec_i,
    output logic [NUM_SRC*LVL_W-1:0] prio_flat_o,
    output logic [NUM_SRC*PC_W-1:0]  vec_flat_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0][LVL_W-1:0] prio;
        logic [NUM_SRC-1:0][PC_W-1:0]  vec;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (we_i && (int'(idx_i) == i)) begin
                tbl_d.prio[i] = prio_i;
                tbl_d.vec[i]  = vec_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign prio_flat_o = tbl_q.prio;
    assign vec_flat_o  = tbl_q.vec;
endmodule

// File: rtl/nic_prio_arb.sv
module nic_prio_arb #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] prio_flat_i,
    input  logic [LVL_W-1:0]         level_i,
    output logic                     win_valid_o,
    output logic [IDX_W-1:0]         win_id_o,
    output logic [LVL_W-1:0]         win_prio_o
);
    logic [NUM_SRC-1:0] elig;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = req_i[g] && (prio_flat_i[g*LVL_W +: LVL_W] > level_i);
    end

    always_comb begin
        win_valid_o = 1'b0;
        win_id_o    = '0;
        win_prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_valid_o || prio_flat_i[i*LVL_W +: LVL_W] > win_prio_o)) begin
                win_valid_o = 1'b1;
                win_id_o    = IDX_W'(i);
                win_prio_o  = prio_flat_i[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/nic_ctx_stack.sv
module nic_ctx_stack #(
    parameter int DEPTH  = 8,
    parameter int ENT_W  = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [ENT_W-1:0] push_data_i,
    output logic [ENT_W-1:0] top_data_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    assign empty_o = (stk_q.cnt == '0);
    assign full_o  = (stk_q.cnt == CNT_W'(DEPTH));
    assign count_o = stk_q.cnt;

    always_comb begin
        top_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(stk_q.cnt) == i + 1) top_data_o = stk_q.mem[i];
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (push_i && !full_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(stk_q.cnt) == i) stk_d.mem[i] = push_data_i;
            end
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop_i && !empty_o) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC          = 8,
    parameter int LVL_W            = 3,
    parameter int PC_W             = 16,
    parameter int STACK_DEPTH      = 8,
    parameter logic [15:0] TRAP_VEC = 16'h0080,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [LVL_W-1:0]   cfg_prio_i,
    input  logic [PC_W-1:0]    cfg_vec_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               rfi_i,
    input  logic               trap_i,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_new_o,
    output logic [LVL_W-1:0]   psr_level_o,
    output logic               psr_priv_o,
    output logic               irq_taken_o,
    output logic [IDX_W-1:0]   irq_id_o,
    output logic [CNT_W-1:0]   depth_o,
    output logic               ovf_err_o,
    output logic               unf_err_o
);
    localparam int ENT_W = PC_W + 1 + LVL_W;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic             priv;
        logic [LVL_W-1:0] lvl;
    } ctx_t;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             priv;
        logic             pc_load;
        logic [PC_W-1:0]  pc_new;
        logic             taken;
        logic [IDX_W-1:0] id;
        logic             ovf;
        logic             unf;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC*LVL_W-1:0] prio_flat;
    logic [NUM_SRC*PC_W-1:0]  vec_flat;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_id;
    logic [LVL_W-1:0]         win_prio;
    logic                     stk_push, stk_pop, stk_empty, stk_full;
    ctx_t                     push_ctx, top_ctx;
    logic [ENT_W-1:0]         top_raw;
    nic_event_e               ev;

    nic_cfg_table #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PC_W(PC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
        .prio_i(cfg_prio_i), .vec_i(cfg_vec_i),
        .prio_flat_o(prio_flat), .vec_flat_o(vec_flat)
    );

    nic_prio_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .req_i(irq_req_i), .prio_flat_i(prio_flat), .level_i(st_q.lvl),
        .win_valid_o(win_valid), .win_id_o(win_id), .win_prio_o(win_prio)
    );

    nic_ctx_stack #(.DEPTH(STACK_DEPTH), .ENT_W(ENT_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(stk_push), .pop_i(stk_pop),
        .push_data_i(push_ctx), .top_data_o(top_raw),
        .empty_o(stk_empty), .full_o(stk_full), .count_o(depth_o)
    );

    assign top_ctx  = ctx_t'(top_raw);
    assign push_ctx = '{pc: pc_i, priv: st_q.priv, lvl: st_q.lvl};

    // one event per cycle: return, then trap, then interrupt
    always_comb begin
        if (rfi_i)          ev = EV_RET;
        else if (trap_i)    ev = EV_TRAP;
        else if (win_valid) ev = EV_IRQ;
        else                ev = EV_NONE;
    end

    always_comb begin
        st_d         = st_q;
        st_d.pc_load = 1'b0;
        st_d.taken   = 1'b0;
        stk_push     = 1'b0;
        stk_pop      = 1'b0;
        unique case (ev)
            EV_RET: begin
                if (stk_empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    stk_pop      = 1'b1;
                    st_d.lvl     = top_ctx.lvl;
                    st_d.priv    = top_ctx.priv;
                    st_d.pc_new  = top_ctx.pc;
                    st_d.pc_load = 1'b1;
                end
            end
            EV_TRAP: begin
                if (stk_full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    stk_push     = 1'b1;
                    st_d.priv    = 1'b1;
                    st_d.pc_new  = PC_W'(TRAP_VEC);
                    st_d.pc_load = 1'b1;
                end
            end
            EV_IRQ: begin
                if (stk_full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    stk_push     = 1'b1;
                    st_d.lvl     = win_prio;
                    st_d.priv    = 1'b1;
                    st_d.pc_new  = vec_flat[int'(win_id)*PC_W +: PC_W];
                    st_d.pc_load = 1'b1;
                    st_d.taken   = 1'b1;
                    st_d.id      = win_id;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_load_o   = st_q.pc_load;
    assign pc_new_o    = st_q.pc_new;
    assign psr_level_o = st_q.lvl;
    assign psr_priv_o  = st_q.priv;
    assign irq_taken_o = st_q.taken;
    assign irq_id_o    = st_q.id;
    assign ovf_err_o   = st_q.ovf;
    assign unf_err_o   = st_q.unf;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int LVL_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_taken_o,
    input logic             pc_load_o,
    input logic             psr_priv_o,
    input logic [LVL_W-1:0] psr_level_o,
    input logic [CNT_W-1:0] depth_o,
    input logic             ovf_err_o,
    input logic             unf_err_o
);
    a_r3_taken_loads: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken_o |-> (pc_load_o && psr_priv_o));

    a_r2_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken_o |-> (psr_level_o > $past(psr_level_o)));

    a_r4_one_push: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken_o |-> (depth_o == $past(depth_o) + 1'b1));

    a_r6_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == $past(depth_o)) || (depth_o == $past(depth_o) + 1'b1)
        || (depth_o + 1'b1 == $past(depth_o)));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);

    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err_o |=> unf_err_o);

    a_r10_unf_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_err_o) |-> ($stable(depth_o) && $stable(psr_level_o) && !pc_load_o));
endmodule

bind nested_irq_ctrl nic_checker #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_taken_o(irq_taken_o), .pc_load_o(pc_load_o),
    .psr_priv_o(psr_priv_o), .psr_level_o(psr_level_o), .depth_o(depth_o),
    .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
    localparam int N = 8, LW = 3, PW = 16, SD = 8, IW = 3, CW = 4;
    localparam logic [15:0] TV = 16'h0080;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] req = '0;
    logic cfg_we = 0; logic [IW-1:0] cfg_idx = '0; logic [LW-1:0] cfg_prio = '0;
    logic [PW-1:0] cfg_vec = '0, pc = '0;
    logic rfi = 0, trap = 0;
    logic pc_load, psr_priv, taken, ovf, unf;
    logic [PW-1:0] pc_new; logic [LW-1:0] lvl; logic [IW-1:0] id; logic [CW-1:0] depth;

    always #4 clk = ~clk;

    nested_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
        .cfg_prio_i(cfg_prio), .cfg_vec_i(cfg_vec), .pc_i(pc), .rfi_i(rfi), .trap_i(trap),
        .pc_load_o(pc_load), .pc_new_o(pc_new), .psr_level_o(lvl), .psr_priv_o(psr_priv),
        .irq_taken_o(taken), .irq_id_o(id), .depth_o(depth), .ovf_err_o(ovf), .unf_err_o(unf)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    logic [LW-1:0] m_prio [N];
    logic [PW-1:0] m_vec  [N];
    logic [PW-1:0] s_pc   [SD];
    logic [LW-1:0] s_lvl  [SD];
    logic          s_priv [SD];
    int m_cnt;
    logic [LW-1:0] m_lvl; logic m_priv, m_load, m_taken, m_ovf, m_unf;
    logic [PW-1:0] m_pcn; logic [IW-1:0] m_id;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_vec[i] = '0; end
        m_cnt = 0; m_lvl = '0; m_priv = 0; m_load = 0; m_taken = 0;
        m_ovf = 0; m_unf = 0; m_pcn = '0; m_id = '0;
    endtask

    task automatic model_step();
        bit wv; int wi; logic [LW-1:0] wp;
        wv = 0; wi = 0; wp = '0;
        for (int i = 0; i < N; i++)
            if (req[i] && m_prio[i] > m_lvl && (!wv || m_prio[i] > wp)) begin
                wv = 1; wi = i; wp = m_prio[i];
            end
        m_load = 0; m_taken = 0;
        if (rfi) begin
            if (m_cnt == 0) m_unf = 1;
            else begin
                m_cnt--; m_lvl = s_lvl[m_cnt]; m_priv = s_priv[m_cnt];
                m_pcn = s_pc[m_cnt]; m_load = 1;
            end
        end else if (trap || wv) begin
            if (m_cnt == SD) m_ovf = 1;
            else begin
                s_pc[m_cnt] = pc; s_lvl[m_cnt] = m_lvl; s_priv[m_cnt] = m_priv; m_cnt++;
                m_priv = 1; m_load = 1;
                if (trap) m_pcn = TV;
                else begin m_lvl = wp; m_pcn = m_vec[wi]; m_taken = 1; m_id = IW'(wi); end
            end
        end
        if (cfg_we) begin m_prio[cfg_idx] = cfg_prio; m_vec[cfg_idx] = cfg_vec; end
    endtask

    task automatic compare(string tag);
        chk({tag, " level"}, 32'(lvl), 32'(m_lvl));
        chk({tag, " priv"},  32'(psr_priv), 32'(m_priv));
        chk({tag, " load"},  32'(pc_load), 32'(m_load));
        chk({tag, " taken"}, 32'(taken), 32'(m_taken));
        chk({tag, " depth"}, 32'(depth), 32'(m_cnt));
        chk({tag, " ovf"},   32'(ovf), 32'(m_ovf));
        chk({tag, " unf"},   32'(unf), 32'(m_unf));
        if (m_load)  chk({tag, " pc_new"}, 32'(pc_new), 32'(m_pcn));
        if (m_taken) chk({tag, " id"}, 32'(id), 32'(m_id));
    endtask

    // drive at negedge, evaluate model, check just after the next rising edge
    task automatic step(string tag);
        model_step();
        @(posedge clk); #1;
        compare(tag);
        @(negedge clk);
        rfi = 0; trap = 0; cfg_we = 0;
    endtask

    task automatic cfg(int idx, int pr, int vec);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_prio = LW'(pr); cfg_vec = PW'(vec);
        step("R11 cfg");
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1; compare("R1 reset");
        // R10: return on empty stack
        rfi = 1; step("R10 underflow");
        // R11: program table; sources 2 and 7 share priority 3
        for (int i = 0; i < N; i++) cfg(i, (i == 7) ? 3 : i + 1, 16'h100 + i * 16);
        // R2: tie at level 3, lowest index wins
        req = 8'b1000_0100; pc = 16'h1000; step("R2 tie");
        // R4: held request does not retrigger
        step("R4 no retrigger");
        // R2: equal to level is not eligible (source 2 at prio 3 while level 3)
        req = 8'b0000_0100; step("R2 strict");
        // R3: higher source nests
        req = 8'b0010_0100; pc = 16'h2000; step("R3 nest");
        // R5: lower pending until returns
        req = 8'b0000_0011; step("R5 pending");
        rfi = 1; step("R6 pop1");
        rfi = 1; step("R6 pop2");
        step("R5 taken after return");
        // R7: trap keeps level
        req = '0; trap = 1; pc = 16'h3000; step("R7 trap");
        // R8: return and trap and irq in one cycle, return wins
        req = 8'b1000_0000; rfi = 1; trap = 1; step("R8 order ret");
        req = 8'b1000_0000; trap = 1; step("R8 order trap");
        req = '0;
        // R9: fill then overflow
        for (int k = 0; k < SD + 1; k++) begin trap = 1; pc = PW'(k); step("R9 fill"); end
        req = 8'b1000_0000; step("R9 irq on full");
        req = '0;
        for (int k = 0; k < SD + 2; k++) begin rfi = 1; step("R6 drain"); end
        // random traffic
        for (int c = 0; c < 4000; c++) begin
            req = N'($urandom);
            if ($urandom_range(0, 3) == 0) req = '0;
            pc = PW'($urandom);
            rfi  = ($urandom_range(0, 4) == 0);
            trap = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 29) == 0) begin
                cfg_we = 1; cfg_idx = IW'($urandom); cfg_prio = LW'($urandom);
                cfg_vec = PW'($urandom);
            end
            step("R2 R3 R6 R7 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule